// File: doc/BRIEF.md
# Active Priority Stack Tracker

This block keeps the preemption state of a single processor interrupt interface. Each time an interrupt is acknowledged, it reduces the interrupt's 8-bit priority to a group priority. The reduction uses a binary point. Group-1 interrupts can use a separate aliased binary point. The block then records the resulting preemption level as one bit in an active-level bitmap. There is one bitmap for group 0 and one for group 1. The running priority becomes that group priority.

When an end-of-interrupt arrives, the block retires the most urgent active level of the named group. It then takes the new running priority from the most urgent level still active in either bitmap. Because every active level is held as a separate bit, nested interrupts unwind in order across successive completions.

The block also holds the two binary-point values. It clamps each value on write. Request arbitration and register decoding are handled elsewhere.

Top module: `active_prio_stack`

## Requirements
- R1: After reset, `run_prio` is 0x100 (idle). `bp_norm` equals `MIN_BP`, and `bp_alias` equals `MIN_BP`+1.
- R2: An acknowledge forms the group priority as `ack_prio` AND (0xFF shifted left by binary point + 1). `run_prio` shows this value in the cycle after the strobe.
- R3: The aliased binary point is used when `ack_grp`=1 (group 1) and `common_bp`=0. In every other case the normal binary point is used.
- R4: An acknowledge marks preemption level = group priority >> (`MIN_BP`+1) as active in the bitmap of its group (`ack_grp`: 0 or 1).
- R5: An accepted end-of-interrupt clears only the most urgent active level (the lowest level index) of the group named by `eoi_grp`. The other group's levels stay active.
- R6: After an accepted end-of-interrupt, `run_prio` equals the lowest active level across both groups, shifted left by (`MIN_BP`+1). If no level is active, it is 0x100.
- R7: An end-of-interrupt is ignored while `run_prio` is 0x100.
- R8: An end-of-interrupt whose `eoi_id` is NUM_IRQ or above is ignored.
- R9: A binary-point write (`bp_wr_alias`=0 selects normal, 1 selects aliased) keeps only `bp_wdata[2:0]`. The stored value is raised to at least `MIN_BP` for the normal binary point, or `MIN_BP`+1 for the aliased one.
- R10: When an acknowledge and an end-of-interrupt arrive in the same cycle, the acknowledge is applied and the end-of-interrupt is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_prio | input | PRIO_W | Priority of the acknowledged interrupt |
| ack_grp | input | 1 | Group of the acknowledged interrupt |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_grp | input | 1 | Group of the completed interrupt |
| eoi_id | input | ID_W | Identifier of the completed interrupt |
| bp_wr_en | input | 1 | Binary-point write strobe |
| bp_wr_alias | input | 1 | Write target: 0 normal, 1 aliased |
| bp_wdata | input | 8 | Binary-point write data |
| common_bp | input | 1 | Group 1 uses the normal binary point |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |
| bp_norm | output | 3 | Stored normal binary point |
| bp_alias | output | 3 | Stored aliased binary point |

## Verification
A lost or stray bit in an active-level bitmap stays hidden while a more urgent level is active. It shows up on `run_prio` only in the cycle after the end-of-interrupt that uncovers it. Because of this, the stimulus builds stacks of nested levels across both groups and unwinds them one completion at a time. A wrong bitmap or binary-point selection then changes `run_prio` one cycle after the strobe that exposes it. The reference model is compared on every clock, so any divergence is reported at that edge.

// File: rtl/aps_pkg.sv
package aps_pkg;
   typedef enum logic {GRP_0 = 1'b0, GRP_1 = 1'b1} grp_e;
   localparam int BP_W = 3;
endpackage

// File: rtl/aps_group_prio.sv
module aps_group_prio #(
   parameter int PRIO_W = 8,
   parameter int MIN_BP = 0,
   localparam int SH = MIN_BP + 1,
   localparam int LW = PRIO_W - SH
) (
   input  logic [PRIO_W-1:0]        prio,
   input  logic                     grp,
   input  logic [aps_pkg::BP_W-1:0] bp_n,
   input  logic [aps_pkg::BP_W-1:0] bp_a,
   input  logic                     common,
   output logic [PRIO_W-1:0]        gprio,
   output logic [LW-1:0]            level
);
   logic [aps_pkg::BP_W-1:0] bp_sel;
   logic [PRIO_W-1:0]        mask;

   always_comb begin
      bp_sel = (grp == aps_pkg::GRP_1 && !common) ? bp_a : bp_n;
      mask   = {PRIO_W{1'b1}} << ({1'b0, bp_sel} + 4'd1);
      gprio  = prio & mask;
      level  = gprio[PRIO_W-1:SH];
   end
endmodule

// File: rtl/aps_level_map.sv
module aps_level_map #(
   parameter int LEVELS = 128,
   localparam int LW = $clog2(LEVELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [LW-1:0]     set_idx,
   input  logic              clr_en,
   output logic [LEVELS-1:0] bits,
   output logic [LEVELS-1:0] bits_nxt
);
   always_comb begin
      bits_nxt = bits;
      if (clr_en) bits_nxt = bits & (bits - LEVELS'(1));
      if (set_en) bits_nxt = bits_nxt | (LEVELS'(1) << set_idx);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bits <= '0;
      else        bits <= bits_nxt;
   end

   assert_clear_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !set_en && (bits != '0)) |=>
         ($countones(bits) == $countones($past(bits)) - 1));
endmodule

// File: rtl/aps_lowest_level.sv
module aps_lowest_level #(
   parameter int LEVELS = 128,
   localparam int LW = $clog2(LEVELS)
) (
   input  logic [LEVELS-1:0] vec,
   output logic              any,
   output logic [LW-1:0]     idx
);
   always_comb begin
      any = |vec;
      idx = '0;
      for (int i = LEVELS - 1; i >= 0; i--) begin
         if (vec[i]) idx = LW'(i);
      end
   end
endmodule

// File: rtl/active_prio_stack.sv
module active_prio_stack #(
   parameter int PRIO_W  = 8,
   parameter int MIN_BP  = 0,
   parameter int NUM_IRQ = 96,
   parameter int ID_W    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack_valid,
   input  logic [PRIO_W-1:0] ack_prio,
   input  logic              ack_grp,
   input  logic              eoi_valid,
   input  logic              eoi_grp,
   input  logic [ID_W-1:0]   eoi_id,
   input  logic              bp_wr_en,
   input  logic              bp_wr_alias,
   input  logic [7:0]        bp_wdata,
   input  logic              common_bp,
   output logic [PRIO_W:0]   run_prio,
   output logic [2:0]        bp_norm,
   output logic [2:0]        bp_alias
);
   localparam int SH      = MIN_BP + 1;
   localparam int LW      = PRIO_W - SH;
   localparam int LEVELS  = 1 << LW;
   localparam int MIN_ABP = (MIN_BP < 7) ? MIN_BP + 1 : 7;
   localparam logic [PRIO_W:0] IDLE = (PRIO_W+1)'(1) << PRIO_W;

   if (PRIO_W < 4 || PRIO_W > 10) begin : g_bad_prio_w
      $error("PRIO_W out of supported range");
   end
   if (MIN_BP < 0 || MIN_BP > 3 || SH >= PRIO_W) begin : g_bad_min_bp
      $error("MIN_BP out of supported range");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > (1 << ID_W)) begin : g_bad_num_irq
      $error("NUM_IRQ does not fit ID_W");
   end

   logic [PRIO_W-1:0] gprio;
   logic [LW-1:0]     ack_level;
   logic              eoi_ok;
   logic [LEVELS-1:0] map_q   [2];
   logic [LEVELS-1:0] map_nxt [2];
   logic              any_nxt;
   logic [LW-1:0]     low_nxt;

   aps_group_prio #(.PRIO_W(PRIO_W), .MIN_BP(MIN_BP)) u_gprio (
      .prio(ack_prio), .grp(ack_grp), .bp_n(bp_norm), .bp_a(bp_alias),
      .common(common_bp), .gprio(gprio), .level(ack_level));

   assign eoi_ok = eoi_valid && !ack_valid && !run_prio[PRIO_W]
                   && (32'(eoi_id) < NUM_IRQ);

   for (genvar g = 0; g < 2; g++) begin : g_map
      aps_level_map #(.LEVELS(LEVELS)) u_map (
         .clk(clk), .rst_n(rst_n),
         .set_en(ack_valid && (ack_grp == g[0])),
         .set_idx(ack_level),
         .clr_en(eoi_ok && (eoi_grp == g[0])),
         .bits(map_q[g]), .bits_nxt(map_nxt[g]));
   end

   aps_lowest_level #(.LEVELS(LEVELS)) u_low (
      .vec(map_nxt[0] | map_nxt[1]), .any(any_nxt), .idx(low_nxt));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_prio <= IDLE;
         bp_norm  <= 3'(MIN_BP);
         bp_alias <= 3'(MIN_ABP);
      end else begin
         if (ack_valid)   run_prio <= {1'b0, gprio};
         else if (eoi_ok) run_prio <= any_nxt ? {1'b0, low_nxt, {SH{1'b0}}} : IDLE;
         if (bp_wr_en) begin
            if (bp_wr_alias)
               bp_alias <= (bp_wdata[2:0] < 3'(MIN_ABP)) ? 3'(MIN_ABP) : bp_wdata[2:0];
            else
               bp_norm  <= (bp_wdata[2:0] < 3'(MIN_BP)) ? 3'(MIN_BP) : bp_wdata[2:0];
         end
      end
   end

   assert_ack_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |=> !run_prio[PRIO_W]);
   assert_idle_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_prio == IDLE) == ((map_q[0] | map_q[1]) == '0));
   assert_eoi_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && !ack_valid && run_prio[PRIO_W]) |=> $stable(run_prio));
   assert_eoi_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && !ack_valid && (32'(eoi_id) >= NUM_IRQ)) |=> $stable(run_prio));
   assert_bp_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bp_norm >= 3'(MIN_BP)) && (bp_alias >= 3'(MIN_ABP)));
endmodule

// File: tb/tb_active_prio_stack.sv
module tb_active_prio_stack;
   localparam int MIN_BP = 0;
   localparam int NUM_IRQ = 96;

   logic clk = 0, rst_n = 0;
   logic ack_valid = 0, ack_grp = 0, eoi_valid = 0, eoi_grp = 0;
   logic [7:0] ack_prio = 0, bp_wdata = 0;
   logic [9:0] eoi_id = 0;
   logic bp_wr_en = 0, bp_wr_alias = 0, common_bp = 0;
   logic [8:0] run_prio;
   logic [2:0] bp_norm, bp_alias;

   active_prio_stack #(.MIN_BP(MIN_BP), .NUM_IRQ(NUM_IRQ)) dut (.*);

   always #5 clk = ~clk;

   int total = 0, bad = 0;
   string cur_req = "R1";
   bit started = 0;
   bit [127:0] mm [2];
   int mrun, mbpn, mbpa;

   function automatic int lowest(bit [127:0] v);
      for (int i = 0; i < 128; i++) if (v[i]) return i;
      return -1;
   endfunction

   always @(posedge clk) begin
      started <= 1;
      if (!rst_n) begin
         mm[0] = '0; mm[1] = '0; mrun = 256; mbpn = MIN_BP; mbpa = MIN_BP + 1;
      end else begin
         int bp, gp, lv;
         if (ack_valid) begin
            bp = (ack_grp && !common_bp) ? mbpa : mbpn;
            gp = ack_prio & ((255 << (bp + 1)) & 255);
            lv = gp >> (MIN_BP + 1);
            mm[ack_grp][lv] = 1'b1;
            mrun = gp;
         end else if (eoi_valid && mrun != 256 && eoi_id < NUM_IRQ) begin
            lv = lowest(mm[eoi_grp]);
            if (lv >= 0) mm[eoi_grp][lv] = 1'b0;
            lv = lowest(mm[0] | mm[1]);
            mrun = (lv < 0) ? 256 : (lv << (MIN_BP + 1));
         end
         if (bp_wr_en) begin
            if (bp_wr_alias) mbpa = (bp_wdata[2:0] < MIN_BP + 1) ? MIN_BP + 1 : bp_wdata[2:0];
            else             mbpn = (bp_wdata[2:0] < MIN_BP) ? MIN_BP : bp_wdata[2:0];
         end
      end
   end

   task automatic chk(string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
      end
   endtask

   always @(negedge clk) if (started) begin
      chk("run_prio", run_prio, mrun);
      chk("bp_norm", bp_norm, mbpn);
      chk("bp_alias", bp_alias, mbpa);
   end

   task automatic cyc();
      @(negedge clk);
      ack_valid = 0; eoi_valid = 0; bp_wr_en = 0;
   endtask
   task automatic ack(int p, int g);
      ack_valid = 1; ack_prio = 8'(p); ack_grp = g[0]; cyc();
   endtask
   task automatic eoi(int g, int id);
      eoi_valid = 1; eoi_grp = g[0]; eoi_id = 10'(id); cyc();
   endtask
   task automatic bpw(int al, int d);
      bp_wr_en = 1; bp_wr_alias = al[0]; bp_wdata = 8'(d); cyc();
   endtask

   task automatic expect_run(int exp);
      total++;
      if (run_prio != 9'(exp)) begin
         bad++;
         $display("FAIL %s directed run_prio actual=%0h expected=%0h", cur_req, run_prio, exp);
      end
   endtask

   initial begin
      #200000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1"; expect_run(256);
      rst_n = 1; cyc();
      cur_req = "R9"; bpw(0, 8'hF5); bpw(1, 8'h08);
      bpw(0, 2); bpw(1, 3);
      cur_req = "R2"; ack(8'hA7, 0); expect_run(8'hA0);
      cur_req = "R3"; ack(8'h67, 1); expect_run(8'h60);
      common_bp = 1; ack(8'h23, 1); expect_run(8'h20); common_bp = 0;
      cur_req = "R5"; eoi(0, 5); expect_run(8'h20);
      cur_req = "R8"; eoi(1, 200); expect_run(8'h20);
      cur_req = "R4"; eoi(1, 5); expect_run(8'h60);
      cur_req = "R10"; ack_valid = 1; ack_prio = 8'h11; ack_grp = 0;
      eoi_valid = 1; eoi_grp = 1; eoi_id = 3; cyc(); expect_run(8'h10);
      cur_req = "R6"; eoi(0, 1); expect_run(8'h60); eoi(1, 1); expect_run(256);
      cur_req = "R7"; eoi(1, 1); expect_run(256); eoi(0, 1); expect_run(256);
      cur_req = "R4";
      for (int n = 0; n < 600; n++) begin
         int r = $urandom_range(0, 9);
         common_bp = $urandom_range(0, 1) == 1;
         if (r < 4) ack($urandom_range(0, 255), $urandom_range(0, 1));
         else if (r < 8) eoi($urandom_range(0, 1), $urandom_range(0, 120));
         else if (r == 8) bpw($urandom_range(0, 1), $urandom_range(0, 255));
         else cyc();
      end
      cur_req = "R6";
      for (int n = 0; n < 140; n++) eoi(n % 2, 1);
      expect_run(256);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule